// File: doc/BRIEF.md
# Register-File Page Mapper

This block turns a 16-bit virtual address into a 15-bit physical address. It uses a small map of 16 entries that is held entirely in flip-flops. Each entry has a present flag and a 3-bit frame number. The upper four address bits select the entry, and the lower twelve bits are the byte offset inside a 4 KB page. When the entry is present, the frame number replaces the page number and the offset passes through unchanged. When the entry is absent, the block returns no address and raises a fault that carries the page number that missed.

Supervisory software fills and edits the map through a write port. Typical uses are loading a new map at a context switch, or retiring one page and installing another after an eviction. A lookup takes the request in one cycle and gives a registered result at the next clock edge. A write issued in the same cycle as a lookup of the same entry takes effect only after that lookup has been served.

Top module: `pgmap_top`

## Requirements
- R1: The page number is vaddr_i[15:12] and the offset is vaddr_i[11:0]. On a successful lookup, paddr_o[11:0] equals the offset of the request.
- R2: A request is sampled at a rising edge while req_i is 1. If its entry is present, then after that edge valid_o=1, fault_o=0, paddr_o={frame,offset} and fault_vpn_o=0.
- R3: If the requested entry is absent, then after the sampling edge fault_o=1, valid_o=0, paddr_o=0 and fault_vpn_o holds the requested page number.
- R4: In any cycle where req_i was 0 at the sampling edge, the next outputs are valid_o=0, fault_o=0, paddr_o=0 and fault_vpn_o=0.
- R5: While rst_ni is low, all outputs are 0. After reset, every entry is absent, so every request faults until software loads entries.
- R6: When wr_en_i is 1 at an edge, entry wr_vpn_i takes {wr_present_i, wr_pfn_i}. Requests in later cycles see the new value, and all other entries keep their contents.
- R7: If a write and a request to the same entry fall in the same cycle, the request is served with the entry's old value.
- R8: With page 2 mapped to frame 6, address 8192 maps to 24576. With page 5 mapped to frame 3, address 20500 maps to 12308. With page 8 absent, address 32780 faults with page number 8.
- R9: After a remap, the retired entry faults and the newly installed entry maps to its frame. The remap clears the present flag of one entry and writes a frame with present set into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Map write strobe |
| wr_vpn_i | input | 4 | Entry selected for the write |
| wr_present_i | input | 1 | Present flag to store |
| wr_pfn_i | input | 3 | Frame number to store |
| req_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 16 | Virtual address to look up |
| valid_o | output | 1 | Registered: lookup hit a present entry |
| fault_o | output | 1 | Registered: lookup hit an absent entry |
| paddr_o | output | 15 | Registered physical address, 0 unless valid_o |
| fault_vpn_o | output | 4 | Registered faulting page number, 0 unless fault_o |

## Verification
Every result appears one clock edge after its request is sampled. The bench drives its inputs on a falling edge, lets the next rising edge capture them, and reads the outputs on the falling edge that follows. A write takes effect at the same rising edge that captures it. For this reason, the bench model computes the expected outputs from the map as it stood before that edge, and only then applies the write. The same ordering produces the expected result for a write and a lookup to the same entry in the same cycle.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  parameter int unsigned VPN_W = 4;
  parameter int unsigned OFF_W = 12;
  parameter int unsigned PFN_W = 3;

  typedef struct packed {
    logic             present;
    logic [PFN_W-1:0] pfn;
  } pte_t;
endpackage

// File: rtl/pgmap_table.sv
module pgmap_table
  import pgmap_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 1 << VPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  pte_t             wr_pte_i,
  input  logic [VPN_W-1:0] rd_vpn_i,
  output pte_t             rd_pte_o
);
  pte_t tbl_q [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   tbl_q[g] <= '0;
      else if (wr_en_i && wr_vpn_i == VPN_W'(g))     tbl_q[g] <= wr_pte_i;
    end
  end

  // read sees pre-write contents within a cycle
  assign rd_pte_o = tbl_q[rd_vpn_i];

  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(rst_ni)) |-> tbl_q[$past(wr_vpn_i)] == $past(wr_pte_i));
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
  import pgmap_pkg::*;
#(
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [VPN_W-1:0] vpn_o,
  input  pte_t             pte_i,
  output logic             valid_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [VPN_W-1:0] fault_vpn_o
);
  logic [OFF_W-1:0] off;
  logic             hit, miss;

  assign vpn_o = vaddr_i[VA_W-1:OFF_W];
  assign off   = vaddr_i[OFF_W-1:0];
  assign hit   = req_i &&  pte_i.present;
  assign miss  = req_i && !pte_i.present;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      fault_o     <= 1'b0;
      paddr_o     <= '0;
      fault_vpn_o <= '0;
    end else begin
      valid_o     <= hit;
      fault_o     <= miss;
      paddr_o     <= hit  ? {pte_i.pfn, off} : '0;
      fault_vpn_o <= miss ? vpn_o : '0;
    end
  end

  p_one_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));
  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (!valid_o && !fault_o && paddr_o == '0));
  p_offset_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> paddr_o[OFF_W-1:0] == $past(vaddr_i[OFF_W-1:0]));
  p_fault_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_vpn_o == $past(vaddr_i[VA_W-1:OFF_W]) && paddr_o == '0));
endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
  import pgmap_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [VPN_W-1:0]       wr_vpn_i,
  input  logic                   wr_present_i,
  input  logic [PFN_W-1:0]       wr_pfn_i,
  input  logic                   req_i,
  input  logic [VPN_W+OFF_W-1:0] vaddr_i,
  output logic                   valid_o,
  output logic                   fault_o,
  output logic [PFN_W+OFF_W-1:0] paddr_o,
  output logic [VPN_W-1:0]       fault_vpn_o
);
  pte_t             wr_pte, rd_pte;
  logic [VPN_W-1:0] rd_vpn;

  assign wr_pte = '{present: wr_present_i, pfn: wr_pfn_i};

  pgmap_table u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_vpn_i,
    .wr_pte_i (wr_pte),
    .rd_vpn_i (rd_vpn),
    .rd_pte_o (rd_pte)
  );

  pgmap_xlate u_xlate (
    .clk_i, .rst_ni, .req_i, .vaddr_i,
    .vpn_o   (rd_vpn),
    .pte_i   (rd_pte),
    .valid_o, .fault_o, .paddr_o, .fault_vpn_o
  );
endmodule

// File: tb/tb_pgmap_top.sv
module tb_pgmap_top;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_present = 0, req = 0;
  logic [3:0]  wr_vpn = 0;
  logic [2:0]  wr_pfn = 0;
  logic [15:0] vaddr = 0;
  logic        valid, fault;
  logic [14:0] paddr;
  logic [3:0]  fault_vpn;

  int checks = 0, fails = 0;
  bit         m_pres [16];
  logic [2:0] m_pfn  [16];

  always #10 clk = ~clk;

  pgmap_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_vpn_i(wr_vpn),
    .wr_present_i(wr_present), .wr_pfn_i(wr_pfn), .req_i(req), .vaddr_i(vaddr),
    .valid_o(valid), .fault_o(fault), .paddr_o(paddr), .fault_vpn_o(fault_vpn)
  );

  function automatic logic [22:0] expect_out(bit r, logic [15:0] va);
    logic [3:0] p = va[15:12];
    if (!r)         return '0;
    if (m_pres[p])  return {1'b1, 1'b0, m_pfn[p], va[11:0], 4'h0};
    return {1'b0, 1'b1, 15'h0, p};
  endfunction

  task automatic check(string tag, logic [22:0] exp);
    logic [22:0] act = {valid, fault, paddr, fault_vpn};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {v,f,pa,fv}=%h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, edge captures, check at next negedge
  task automatic step(string tag, bit w, logic [3:0] wv, bit wp, logic [2:0] wf,
                      bit r, logic [15:0] va);
    logic [22:0] exp;
    wr_en = w; wr_vpn = wv; wr_present = wp; wr_pfn = wf; req = r; vaddr = va;
    exp = expect_out(r, va);
    @(posedge clk); @(negedge clk);
    if (w) begin m_pres[wv] = wp; m_pfn[wv] = wf; end
    wr_en = 0; req = 0;
    check(tag, exp);
  endtask

  task automatic wr(logic [3:0] v, bit p, logic [2:0] f);
    step("R6", 1, v, p, f, 0, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 16; i++) begin m_pres[i] = 0; m_pfn[i] = 0; end
    req = 1; vaddr = 16'h2000;
    repeat (3) @(negedge clk);
    check("R5 outputs in reset", '0);
    rst_n = 1; req = 0;
    @(negedge clk);
    for (int p = 0; p < 16; p++) step("R5 empty map faults", 0, 0, 0, 0, 1, {p[3:0], 12'h0A5});
    step("R4 idle", 0, 0, 0, 0, 0, 16'hFFFF);

    wr(4'd2, 1, 3'd6); wr(4'd5, 1, 3'd3); wr(4'd1, 1, 3'd1);
    step("R8 8192", 0, 0, 0, 0, 1, 16'd8192);
    check("R8 8192->24576", {2'b10, 15'd24576, 4'h0});
    step("R8 20500", 0, 0, 0, 0, 1, 16'd20500);
    check("R8 20500->12308", {2'b10, 15'd12308, 4'h0});
    step("R8 32780", 0, 0, 0, 0, 1, 16'd32780);
    check("R8 32780 faults page 8", {2'b01, 15'd0, 4'd8});
    step("R1 top offset", 0, 0, 0, 0, 1, 16'h2FFF);

    // R9: evict frame 1 (page 1), install page 8 at frame 1
    wr(4'd1, 0, 3'd1); wr(4'd8, 1, 3'd1);
    step("R9 retired page", 0, 0, 0, 0, 1, 16'h1004);
    check("R9 retired faults", {2'b01, 15'd0, 4'd1});
    step("R9 new page", 0, 0, 0, 0, 1, 16'd32780);
    check("R9 32780->4108", {2'b10, 15'd4108, 4'h0});

    // R7: same-cycle write and lookup, same entry
    step("R7 old present", 1, 4'd2, 1, 3'd4, 1, 16'h2010);
    check("R7 uses frame 6", {2'b10, {3'd6, 12'h010}, 4'h0});
    step("R7 new visible", 0, 0, 0, 0, 1, 16'h2010);
    step("R7 old absent", 1, 4'd9, 1, 3'd7, 1, 16'h9001);
    step("R7 clear while read", 1, 4'd9, 0, 3'd0, 1, 16'h9002);

    // R6: sweep all entries, others unchanged
    for (int p = 0; p < 16; p++) step("R6 sweep", 0, 0, 0, 0, 1, {p[3:0], 12'h321});

    for (int n = 0; n < 400; n++) begin
      bit w = ($urandom % 4) == 0;
      bit r = ($urandom % 4) != 0;
      logic [15:0] va = 16'($urandom);
      string tag = !r ? "R4 random idle" : (m_pres[va[15:12]] ? "R2 random hit" : "R3 random fault");
      step(tag, w, 4'($urandom), 1'($urandom), 3'($urandom), r, va);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule